// File: doc/BRIEF.md
# TDM Push Transmit Engine with Completion Flag

This block is the transmit half of a network interface on a time-division-multiplexed network-on-chip. The processor fills a region of its local scratchpad, then hands the engine a source address, a destination address and a byte length in one start pulse. The engine reads the region as 64-bit chunks and pushes each chunk to the remote scratchpad. It sends only in the one TDM slot per period that the static schedule gives its channel.

The network raises no arrival event at the receiver. The engine therefore sends one extra word after the last chunk: a 32-bit completion flag, placed directly after the payload in the remote address space. The receiving processor polls this word. Because the flag leaves in an owned slot later than every payload chunk, seeing the flag means that all the data is already in place.

Scratchpad addresses and network addresses count 64-bit double words. The schedule parameters are set by default to a 10-slot period of 3-cycle slots, with one slot per period per channel.

Top module: `tdm_push_dma`

## Requirements
- R1: After reset, `busy_o`, `spm_rd_o` and `net_valid_o` are low, and the slot counter starts at slot 0, cycle 0. Counting from the first clock edge after reset is released, slot s, cycle c covers edge index 3*s+c modulo 30.
- R2: A `start_i` pulse sampled while `busy_o` is low captures the source address, destination address and length. `busy_o` is high in the following cycle.
- R3: A `start_i` pulse sampled while `busy_o` is high has no effect. The transfer in progress produces exactly the flits it would have produced without the pulse.
- R4: `net_valid_o` is high only in cycle 2 of slot `CHAN_SLOT`. The slot counter wraps from `PERIOD-1` back to 0.
- R5: Payload flit k (k = 0, 1, ...) carries `net_flag_o`=0, `net_addr_o`=dst+k and `net_data_o` equal to the scratchpad word at src+k. Address sums wrap modulo 2^AW. Successive flits of one transfer, the flag flit included, are exactly PERIOD*SLOT_CYCLES cycles apart.
- R6: The number of payload flits is ceil(len/8). A length that is not a multiple of 8 is padded up to a whole chunk, and a length of 0 sends no payload.
- R7: After the last payload flit, exactly one flag flit follows in the next owned slot. It carries `net_flag_o`=1, `net_addr_o`=dst+ceil(len/8) and `net_data_o`={32'h0, FLAG_VAL}.
- R8: `busy_o` falls in the same cycle that the flag flit is presented, and never at any other time.
- R9: `spm_rd_o` is high only in cycle 0 of slot `CHAN_SLOT`. The read data is expected on `spm_rdata_i` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, one-cycle pulse |
| src_addr_i | input | AW | Scratchpad start address, in double words |
| dst_addr_i | input | AW | Remote start address, in double words |
| len_i | input | LW | Message length in bytes |
| busy_o | output | 1 | High while a transfer is pending |
| spm_rd_o | output | 1 | Scratchpad read strobe |
| spm_addr_o | output | AW | Scratchpad read address |
| spm_rdata_i | input | 64 | Scratchpad read data, one-cycle latency |
| net_valid_o | output | 1 | Flit valid toward the router |
| net_flag_o | output | 1 | Flit is the completion flag |
| net_addr_o | output | AW | Remote write address of the flit |
| net_data_o | output | 64 | Flit payload |

## Verification
The checker assumes three things about the inputs. The scratchpad returns the requested word exactly one cycle after a read strobe. The region being sent is not rewritten while `busy_o` is high. `start_i` is a synchronous pulse. The bench keeps to these assumptions with a scratchpad model whose contents are a fixed function of the address, so that nothing is written during a transfer, and with a driver that pulses start for one cycle at a falling edge. Extra starts are issued during a transfer on purpose, to test that they are ignored, since that case is legal input.

// File: rtl/tdm_dma_pkg.sv
package tdm_dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_FLAG = 2'd2
  } dma_state_e;
endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
  parameter int PERIOD      = 10,
  parameter int SLOT_CYCLES = 3,
  parameter int CHAN_SLOT   = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic fetch_o,
  output logic emit_o
);
  localparam int SW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam int CW = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;

  logic [SW-1:0] slot_q;
  logic [CW-1:0] cyc_q;
  logic          owned;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      cyc_q  <= '0;
    end else if (cyc_q == CW'(SLOT_CYCLES - 1)) begin
      cyc_q  <= '0;
      slot_q <= (slot_q == SW'(PERIOD - 1)) ? '0 : slot_q + SW'(1);
    end else begin
      cyc_q <= cyc_q + CW'(1);
    end
  end

  assign owned   = (slot_q == SW'(CHAN_SLOT));
  assign fetch_o = owned && (cyc_q == CW'(0));
  assign emit_o  = owned && (cyc_q == CW'(1));
endmodule

// File: rtl/tdm_dma_seq.sv
module tdm_dma_seq
  import tdm_dma_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          LW       = 12,
  parameter logic [31:0] FLAG_VAL = 32'h0000_0001
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] dst_addr_i,
  input  logic [LW-1:0] len_i,
  input  logic          fetch_i,
  input  logic          emit_i,
  output logic          busy_o,
  output logic          spm_rd_o,
  output logic [AW-1:0] spm_addr_o,
  input  logic [63:0]   spm_rdata_i,
  output logic          net_valid_o,
  output logic          net_flag_o,
  output logic [AW-1:0] net_addr_o,
  output logic [63:0]   net_data_o
);
  localparam int CHW = LW - 2;

  dma_state_e     state_q;
  logic [AW-1:0]  src_q, dst_q;
  logic [CHW-1:0] nch_q, idx_q, nch_w;
  logic           pend_q;
  logic           vld_q, flg_q;
  logic [AW-1:0]  oaddr_q;
  logic [63:0]    odata_q;

  // chunks = ceil(len/8)
  assign nch_w = CHW'(len_i >> 3) + CHW'(|len_i[2:0]);

  assign busy_o     = (state_q != ST_IDLE);
  assign spm_rd_o   = (state_q == ST_DATA) && fetch_i;
  assign spm_addr_o = src_q + AW'(idx_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      nch_q   <= '0;
      idx_q   <= '0;
      pend_q  <= 1'b0;
      vld_q   <= 1'b0;
      flg_q   <= 1'b0;
      oaddr_q <= '0;
      odata_q <= '0;
    end else begin
      vld_q <= 1'b0;
      flg_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            src_q   <= src_addr_i;
            dst_q   <= dst_addr_i;
            nch_q   <= nch_w;
            idx_q   <= '0;
            pend_q  <= 1'b0;
            state_q <= (nch_w == '0) ? ST_FLAG : ST_DATA;
          end
        end
        ST_DATA: begin
          if (spm_rd_o) begin
            pend_q <= 1'b1;
          end else if (emit_i && pend_q) begin
            pend_q  <= 1'b0;
            vld_q   <= 1'b1;
            oaddr_q <= dst_q + AW'(idx_q);
            odata_q <= spm_rdata_i;
            idx_q   <= idx_q + CHW'(1);
            if (idx_q + CHW'(1) == nch_q) state_q <= ST_FLAG;
          end
        end
        ST_FLAG: begin
          if (emit_i) begin
            vld_q   <= 1'b1;
            flg_q   <= 1'b1;
            oaddr_q <= dst_q + AW'(idx_q);
            odata_q <= {32'h0, FLAG_VAL};
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign net_valid_o = vld_q;
  assign net_flag_o  = flg_q;
  assign net_addr_o  = oaddr_q;
  assign net_data_o  = odata_q;
endmodule

// File: rtl/tdm_push_dma.sv
module tdm_push_dma #(
  parameter int          AW          = 16,
  parameter int          LW          = 12,
  parameter int          PERIOD      = 10,
  parameter int          SLOT_CYCLES = 3,
  parameter int          CHAN_SLOT   = 4,
  parameter logic [31:0] FLAG_VAL    = 32'h0000_0001
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] dst_addr_i,
  input  logic [LW-1:0] len_i,
  output logic          busy_o,
  output logic          spm_rd_o,
  output logic [AW-1:0] spm_addr_o,
  input  logic [63:0]   spm_rdata_i,
  output logic          net_valid_o,
  output logic          net_flag_o,
  output logic [AW-1:0] net_addr_o,
  output logic [63:0]   net_data_o
);
  logic fetch_w, emit_w;

  tdm_slot_timer #(
    .PERIOD     (PERIOD),
    .SLOT_CYCLES(SLOT_CYCLES),
    .CHAN_SLOT  (CHAN_SLOT)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fetch_o(fetch_w),
    .emit_o (emit_w)
  );

  tdm_dma_seq #(
    .AW      (AW),
    .LW      (LW),
    .FLAG_VAL(FLAG_VAL)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .src_addr_i (src_addr_i),
    .dst_addr_i (dst_addr_i),
    .len_i      (len_i),
    .fetch_i    (fetch_w),
    .emit_i     (emit_w),
    .busy_o     (busy_o),
    .spm_rd_o   (spm_rd_o),
    .spm_addr_o (spm_addr_o),
    .spm_rdata_i(spm_rdata_i),
    .net_valid_o(net_valid_o),
    .net_flag_o (net_flag_o),
    .net_addr_o (net_addr_o),
    .net_data_o (net_data_o)
  );
endmodule

// File: rtl/tdm_push_dma_chk.sv
module tdm_push_dma_chk #(
  parameter int LW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [LW-1:0] len_i,
  input logic          busy_o,
  input logic          spm_rd_o,
  input logic          net_valid_o,
  input logic          net_flag_o,
  input logic          fetch_i,
  input logic          emit_i
);
  int exp_q, sent_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q  <= 0;
      sent_q <= 0;
    end else if (start_i && !busy_o) begin
      exp_q  <= (int'(len_i) + 7) / 8;
      sent_q <= 0;
    end else if (net_valid_o && !net_flag_o) begin
      sent_q <= sent_q + 1;
    end
  end

  a_r1_idle_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !spm_rd_o);
  a_r2_start_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o);
  a_r4_emit_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    net_valid_o |-> $past(emit_i));
  a_r9_fetch_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spm_rd_o |-> fetch_i);
  a_r5_no_extra: assert property (@(posedge clk_i) disable iff (!rst_ni)
    net_valid_o && !net_flag_o |-> sent_q < exp_q);
  a_r7_flag_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    net_valid_o && net_flag_o |-> sent_q == exp_q);
  a_r8_flag_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    net_valid_o && net_flag_o |-> !busy_o);
  a_r8_fall_with_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> net_valid_o && net_flag_o);
endmodule

bind tdm_push_dma tdm_push_dma_chk #(.LW(LW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .len_i      (len_i),
  .busy_o     (busy_o),
  .spm_rd_o   (spm_rd_o),
  .net_valid_o(net_valid_o),
  .net_flag_o (net_flag_o),
  .fetch_i    (fetch_w),
  .emit_i     (emit_w)
);

// File: tb/tb_tdm_push_dma.sv
module tb_tdm_push_dma;
  localparam int          AW = 16;
  localparam int          LW = 12;
  localparam int          PERIOD = 10;
  localparam int          SLOT_CYCLES = 3;
  localparam int          CHAN_SLOT = 4;
  localparam logic [31:0] FLAG_VAL = 32'h0000_0001;
  localparam int          GAP = PERIOD * SLOT_CYCLES;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [63:0]   data;
    logic          flag;
  } flit_t;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] src_addr_i = '0, dst_addr_i = '0;
  logic [LW-1:0] len_i = '0;
  logic          busy_o, spm_rd_o, net_valid_o, net_flag_o;
  logic [AW-1:0] spm_addr_o, net_addr_o;
  logic [63:0]   spm_rdata_i = '0, net_data_o;

  int checks = 0, errors = 0;
  int tslot = 0, tcyc = 0, ncyc = 0;
  int last_t = 0;
  bit in_xfer = 0;
  flit_t expq[$];

  always #10 clk_i = ~clk_i;

  tdm_push_dma #(
    .AW(AW), .LW(LW), .PERIOD(PERIOD), .SLOT_CYCLES(SLOT_CYCLES),
    .CHAN_SLOT(CHAN_SLOT), .FLAG_VAL(FLAG_VAL)
  ) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .src_addr_i(src_addr_i), .dst_addr_i(dst_addr_i), .len_i(len_i),
    .busy_o(busy_o), .spm_rd_o(spm_rd_o), .spm_addr_o(spm_addr_o),
    .spm_rdata_i(spm_rdata_i), .net_valid_o(net_valid_o),
    .net_flag_o(net_flag_o), .net_addr_o(net_addr_o), .net_data_o(net_data_o)
  );

  function automatic logic [63:0] mem_word(logic [AW-1:0] a);
    return {a, ~a, a ^ 16'h5A5A, a + 16'h1234};
  endfunction

  // scratchpad model, one-cycle read latency
  always @(posedge clk_i) if (spm_rd_o) spm_rdata_i <= mem_word(spm_addr_o);

  // independent schedule model
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tslot <= 0; tcyc <= 0; ncyc <= 0;
    end else begin
      ncyc <= ncyc + 1;
      if (tcyc == SLOT_CYCLES - 1) begin
        tcyc  <= 0;
        tslot <= (tslot == PERIOD - 1) ? 0 : tslot + 1;
      end else tcyc <= tcyc + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (spm_rd_o)
        chk(tslot == CHAN_SLOT && tcyc == 0, "R9", "read slot/cycle",
            96'(tslot * 16 + tcyc), 96'(CHAN_SLOT * 16));
      if (net_valid_o) begin
        flit_t e;
        chk(tslot == CHAN_SLOT && tcyc == 2, "R4", "emit slot/cycle",
            96'(tslot * 16 + tcyc), 96'(CHAN_SLOT * 16 + 2));
        if (in_xfer)
          chk(ncyc - last_t == GAP, "R5", "flit spacing",
              96'(ncyc - last_t), 96'(GAP));
        if (expq.size() == 0) begin
          chk(1'b0, "R3", "unexpected flit", {net_addr_o, 16'h0, net_data_o}, '0);
        end else begin
          e = expq.pop_front();
          chk(net_flag_o == e.flag, e.flag ? "R7" : "R5", "flag bit",
              96'(net_flag_o), 96'(e.flag));
          chk(net_addr_o == e.addr, e.flag ? "R7" : "R5", "address",
              96'(net_addr_o), 96'(e.addr));
          chk(net_data_o == e.data, e.flag ? "R7" : "R5", "data",
              96'(net_data_o), 96'(e.data));
        end
        if (net_flag_o) begin
          chk(!busy_o, "R8", "busy low with flag", 96'(busy_o), 96'(0));
          in_xfer = 0;
        end else begin
          in_xfer = 1;
        end
        last_t = ncyc;
      end
    end
  end

  task automatic xfer(input logic [AW-1:0] src, input logic [AW-1:0] dst,
                      input logic [LW-1:0] len, input bit poke, input string req);
    int nch = (int'(len) + 7) / 8;
    for (int k = 0; k < nch; k++) begin
      logic [AW-1:0] sa = src + AW'(k);
      expq.push_back({dst + AW'(k), mem_word(sa), 1'b0});
    end
    expq.push_back({dst + AW'(nch), {32'h0, FLAG_VAL}, 1'b1});
    @(negedge clk_i);
    src_addr_i = src; dst_addr_i = dst; len_i = len; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o, "R2", "busy after start", 96'(busy_o), 96'(1));
    if (poke) begin
      repeat (7) @(negedge clk_i);
      src_addr_i = 16'h7777; dst_addr_i = 16'h8888; len_i = 12'd40; start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      chk(busy_o, "R3", "busy after ignored start", 96'(busy_o), 96'(1));
    end
    while (busy_o) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    chk(expq.size() == 0, req, "all flits delivered",
        96'(expq.size()), 96'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !net_valid_o && !spm_rd_o, "R1", "reset outputs",
        96'({busy_o, net_valid_o, spm_rd_o}), 96'(0));
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !net_valid_o && !spm_rd_o, "R1", "after release",
        96'({busy_o, net_valid_o, spm_rd_o}), 96'(0));
    xfer(16'h0100, 16'h2000, 12'd24, 0, "R5");
    xfer(16'h0040, 16'h3000, 12'd13, 0, "R6");
    xfer(16'h0050, 16'h3100, 12'd1,  0, "R6");
    xfer(16'h0000, 16'h4000, 12'd0,  0, "R6");
    xfer(16'h0200, 16'h5000, 12'd32, 1, "R3");
    xfer(16'hFFFF, 16'hFFFE, 12'd24, 0, "R5");
    xfer(16'h0300, 16'h6000, 12'd8,  1, "R7");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule